// File: doc/BRIEF.md
# Bank-Skipping Ring Pointer Unit

This block runs the bookkeeping for a byte FIFO whose storage lives only in the upper, bank-private half of each 32-byte bank of an 8-bit register space. Bit 4 of an address selects that half. The lower half of every bank (bit 4 clear) holds common registers and must never be used. The unit keeps an input pointer, an output pointer and an occupancy count. On each accepted push or pop it issues the logical address to write or read. It does not hold the data and does not map addresses to physical storage.

Moving forward, a pointer steps from the last byte of one bank's private half straight to the first byte of the next bank's private half. When it reaches a configured end address it wraps back to a configured base, and that end address may fall in the middle of a bank. A backward step follows the same layout. The unit uses it to report the address of the newest stored byte.

Configuration rules: `cfg_base` and `cfg_end` both have bit 4 set, `cfg_end` is reachable from `cfg_base` by forward steps, and `cfg_size` is between 1 and the number of slots on that path. All three are held stable outside reset. A new configuration takes effect through a reset.

Top module: `banked_ring_ptr`

## Requirements
- R1: While `rst` is high on a clock edge, both pointers load `cfg_base` and the count clears. Afterwards `empty`=1, `full`=0, `wr_vld`=0, `rd_vld`=0 and `err`=0, and the first accepted push and the first accepted pop both use address `cfg_base`.
- R2: A forward step adds 1 to the 8-bit pointer and then forces bit 4 to 1. For example, 0x1F steps to 0x30 and 0xFF steps to 0x10.
- R3: If a forward step produces a value equal to `cfg_end`, the pointer takes `cfg_base` instead.
- R4: A push request is accepted when the buffer is not full. On the next cycle `wr_vld` is 1 for exactly one cycle and `wr_addr` holds the input pointer's value before the step. The input pointer then steps forward and the count goes up by one.
- R5: `full` is 1 exactly when the count equals `cfg_size`, and a push request made while `full` is 1 is refused.
- R6: A pop request is accepted when `empty` is 0, and `empty` is 1 exactly when the count is zero. On the next cycle `rd_vld` is 1 for one cycle and `rd_addr` holds the output pointer's value before the step. The output pointer then steps forward and the count goes down by one.
- R7: When push and pop are requested in the same cycle and the buffer is neither empty nor full, both are accepted, both pointers advance, and `full` and `empty` keep their values. If the buffer is full, only the pop is accepted. If it is empty, only the push is accepted.
- R8: A refused push or pop raises `err` for one cycle, on the cycle after the request. The refused request changes neither the pointers nor the count.
- R9: `newest_addr` is the backward step of the input pointer. A backward step subtracts 1 and, if bit 4 of the result is then 0, subtracts a further 0x10. When the input pointer equals `cfg_base`, the value stepped back from is `cfg_end` instead. `newest_addr` is updated in the same cycle as the pointer.
- R10: Every address issued with `wr_vld` or `rd_vld` has bit 4 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base | input | ADDR_W | First slot of the ring |
| cfg_end | input | ADDR_W | Address one forward step past the last slot |
| cfg_size | input | CNT_W | Capacity in bytes |
| push_req | input | 1 | Request to store one byte |
| pop_req | input | 1 | Request to take one byte |
| wr_vld | output | 1 | Accepted push, write strobe |
| wr_addr | output | ADDR_W | Address to write |
| rd_vld | output | 1 | Accepted pop, read strobe |
| rd_addr | output | ADDR_W | Address to read |
| newest_addr | output | ADDR_W | Address of the most recently stored byte |
| full | output | 1 | Count equals capacity |
| empty | output | 1 | Count is zero |
| err | output | 1 | A request was refused on the previous cycle |

## Verification
The hardest cases are the ones where a pointer reaches `cfg_end` just as it crosses a bank boundary, and where both requests arrive at the exact moment the buffer is full or empty. Only a long, precisely counted run of traffic reaches them. The stimulus fills the ring exactly to `cfg_size`, keeps requesting past full and past empty, and then holds dual traffic long enough for both pointers to wrap several times. It does this under two configurations: one whose ring ends mid-bank, and one whose ring crosses from 0xFF back to 0x10.

// File: rtl/brp_pkg.sv
package brp_pkg;
  // Direction of one pointer move through the bank-private halves
  typedef enum logic {
    STEP_FWD  = 1'b0,
    STEP_BACK = 1'b1
  } step_dir_e;
endpackage

// File: rtl/brp_stepper.sv
module brp_stepper #(
  parameter int                 ADDR_W  = 8,
  parameter int                 SEL_BIT = 4,
  parameter brp_pkg::step_dir_e DIR     = brp_pkg::STEP_FWD
) (
  input  logic [ADDR_W-1:0] ptr,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] lim,
  output logic [ADDR_W-1:0] nxt
);
  localparam logic [ADDR_W-1:0] ONE  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] HALF = ONE << SEL_BIT;

  generate
    if (DIR == brp_pkg::STEP_FWD) begin : g_fwd
      logic [ADDR_W-1:0] raw;
      always_comb begin
        raw          = ptr + ONE;
        raw[SEL_BIT] = 1'b1;          // land in the private half
        nxt          = (raw == lim) ? base : raw;
      end
    end else begin : g_back
      logic [ADDR_W-1:0] src;
      logic [ADDR_W-1:0] dec1;
      always_comb begin
        src  = (ptr == base) ? lim : ptr;
        dec1 = src - ONE;
        nxt  = dec1[SEL_BIT] ? dec1 : (dec1 - HALF);
      end
    end
  endgenerate
endmodule

// File: rtl/brp_occupancy.sv
module brp_occupancy #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             dec,
  input  logic [CNT_W-1:0] cap,
  output logic             full,
  output logic             empty
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (inc && !dec) cnt_n = cnt_q + CNT_W'(1);
    if (dec && !inc) cnt_n = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      full  <= 1'b0;
      empty <= 1'b1;
    end else begin
      cnt_q <= cnt_n;
      full  <= (cnt_n == cap);
      empty <= (cnt_n == '0);
    end
  end
endmodule

// File: rtl/banked_ring_ptr.sv
module banked_ring_ptr #(
  parameter int ADDR_W  = 8,
  parameter int SEL_BIT = 4,
  parameter int CNT_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic [ADDR_W-1:0] cfg_end,
  input  logic [CNT_W-1:0]  cfg_size,
  input  logic              push_req,
  input  logic              pop_req,
  output logic              wr_vld,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              rd_vld,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] newest_addr,
  output logic              full,
  output logic              empty,
  output logic              err
);
  logic [ADDR_W-1:0] in_ptr_q, out_ptr_q;
  logic [ADDR_W-1:0] in_step, out_step, in_next, back_src, back_val;
  logic              push_ok, pop_ok;

  assign push_ok = push_req && !full;
  assign pop_ok  = pop_req && !empty;

  brp_stepper #(.ADDR_W(ADDR_W), .SEL_BIT(SEL_BIT), .DIR(brp_pkg::STEP_FWD)) u_in_step (
    .ptr(in_ptr_q), .base(cfg_base), .lim(cfg_end), .nxt(in_step)
  );
  brp_stepper #(.ADDR_W(ADDR_W), .SEL_BIT(SEL_BIT), .DIR(brp_pkg::STEP_FWD)) u_out_step (
    .ptr(out_ptr_q), .base(cfg_base), .lim(cfg_end), .nxt(out_step)
  );

  assign in_next  = push_ok ? in_step : in_ptr_q;
  assign back_src = rst ? cfg_base : in_next;

  brp_stepper #(.ADDR_W(ADDR_W), .SEL_BIT(SEL_BIT), .DIR(brp_pkg::STEP_BACK)) u_newest (
    .ptr(back_src), .base(cfg_base), .lim(cfg_end), .nxt(back_val)
  );

  brp_occupancy #(.CNT_W(CNT_W)) u_occ (
    .clk(clk), .rst(rst), .inc(push_ok), .dec(pop_ok), .cap(cfg_size),
    .full(full), .empty(empty)
  );

  always_ff @(posedge clk) begin
    newest_addr <= back_val;
    if (rst) begin
      in_ptr_q  <= cfg_base;
      out_ptr_q <= cfg_base;
      wr_vld    <= 1'b0;
      rd_vld    <= 1'b0;
      wr_addr   <= '0;
      rd_addr   <= '0;
      err       <= 1'b0;
    end else begin
      in_ptr_q <= in_next;
      if (pop_ok) out_ptr_q <= out_step;
      wr_vld <= push_ok;
      rd_vld <= pop_ok;
      if (push_ok) wr_addr <= in_ptr_q;
      if (pop_ok)  rd_addr <= out_ptr_q;
      err <= (push_req && full) || (pop_req && empty);
    end
  end
endmodule

// File: rtl/banked_ring_ptr_chk.sv
module banked_ring_ptr_chk #(
  parameter int ADDR_W  = 8,
  parameter int SEL_BIT = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              push_req,
  input logic              pop_req,
  input logic              wr_vld,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              rd_vld,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              full,
  input logic              empty,
  input logic              err
);
  assert_not_full_and_empty_R5: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));
  assert_push_taken_R4: assert property (@(posedge clk) disable iff (rst)
    push_req && !full |=> wr_vld);
  assert_pop_taken_R6: assert property (@(posedge clk) disable iff (rst)
    pop_req && !empty |=> rd_vld);
  assert_push_refused_R8: assert property (@(posedge clk) disable iff (rst)
    push_req && full |=> err && !wr_vld);
  assert_pop_refused_R8: assert property (@(posedge clk) disable iff (rst)
    pop_req && empty |=> err && !rd_vld);
  assert_dual_level_R7: assert property (@(posedge clk) disable iff (rst)
    push_req && pop_req && !full && !empty |=> $stable(full) && $stable(empty));
  assert_wr_private_R10: assert property (@(posedge clk) disable iff (rst)
    wr_vld |-> wr_addr[SEL_BIT]);
  assert_rd_private_R10: assert property (@(posedge clk) disable iff (rst)
    rd_vld |-> rd_addr[SEL_BIT]);
endmodule

bind banked_ring_ptr banked_ring_ptr_chk #(.ADDR_W(ADDR_W), .SEL_BIT(SEL_BIT)) u_chk (
  .clk(clk), .rst(rst), .push_req(push_req), .pop_req(pop_req),
  .wr_vld(wr_vld), .wr_addr(wr_addr), .rd_vld(rd_vld), .rd_addr(rd_addr),
  .full(full), .empty(empty), .err(err)
);

// File: tb/banked_ring_ptr_bench.sv
module banked_ring_ptr_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] cfg_base = 8'h1A, cfg_end = 8'h54, cfg_size = 8'd26;
  logic       push_req = 1'b0, pop_req = 1'b0;
  logic       wr_vld, rd_vld, full, empty, err;
  logic [7:0] wr_addr, rd_addr, newest_addr;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_ring_ptr u_banked_ring_ptr (
    .clk(clk), .rst(rst), .cfg_base(cfg_base), .cfg_end(cfg_end), .cfg_size(cfg_size),
    .push_req(push_req), .pop_req(pop_req), .wr_vld(wr_vld), .wr_addr(wr_addr),
    .rd_vld(rd_vld), .rd_addr(rd_addr), .newest_addr(newest_addr),
    .full(full), .empty(empty), .err(err)
  );

  typedef struct {
    logic       wv; logic [7:0] wa;
    logic       rv; logic [7:0] ra;
    logic       er; logic fu; logic em;
    logic [7:0] nw;
  } exp_t;

  exp_t       exp_q[$];
  logic [7:0] obs_wr[$];
  logic [7:0] m_in, m_out;
  int         m_cnt;

  task automatic chk(string req, string what, logic [7:0] act, logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Forward step from R2/R3
  function automatic logic [7:0] fwd(logic [7:0] p);
    logic [7:0] r;
    r = p + 8'd1;
    r = r | 8'h10;
    return (r == cfg_end) ? cfg_base : r;
  endfunction

  // Backward step from R9
  function automatic logic [7:0] back(logic [7:0] p);
    logic [7:0] s;
    s = (p == cfg_base) ? cfg_end : p;
    s = s - 8'd1;
    if (s[4] == 1'b0) s = s - 8'h10;
    return s;
  endfunction

  task automatic cycle(bit ps, bit pp);
    exp_t e;
    bit   ap, ao;
    @(negedge clk);
    push_req = ps;
    pop_req  = pp;
    ap = ps && (m_cnt != int'(cfg_size));
    ao = pp && (m_cnt != 0);
    e.wv = ap; e.wa = m_in;
    e.rv = ao; e.ra = m_out;
    e.er = (ps && !ap) || (pp && !ao);
    if (ap) begin m_in = fwd(m_in); m_cnt++; end
    if (ao) begin m_out = fwd(m_out); m_cnt--; end
    e.fu = (m_cnt == int'(cfg_size));
    e.em = (m_cnt == 0);
    e.nw = back(m_in);
    exp_q.push_back(e);
  endtask

  task automatic run(int n, bit ps, bit pp);
    for (int i = 0; i < n; i++) cycle(ps, pp);
  endtask

  task automatic do_reset(logic [7:0] b, logic [7:0] en, logic [7:0] sz);
    @(negedge clk);
    rst = 1'b1; push_req = 1'b0; pop_req = 1'b0;
    cfg_base = b; cfg_end = en; cfg_size = sz;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_in = b; m_out = b; m_cnt = 0;
    obs_wr.delete();
    // R1: state right after reset
    chk("R1", "empty", {7'd0, empty}, 8'd1);
    chk("R1", "full", {7'd0, full}, 8'd0);
    chk("R1", "wr_vld", {7'd0, wr_vld}, 8'd0);
    chk("R1", "rd_vld", {7'd0, rd_vld}, 8'd0);
    chk("R1", "err", {7'd0, err}, 8'd0);
    chk("R9", "newest after reset", newest_addr, back(b));
  endtask

  // Monitor: compare each cycle against the scoreboard
  always begin
    exp_t e;
    @(posedge clk);
    #1;
    if (exp_q.size() != 0) begin
      e = exp_q.pop_front();
      chk("R4", "wr_vld", {7'd0, wr_vld}, {7'd0, e.wv});
      if (e.wv) chk("R4", "wr_addr", wr_addr, e.wa);
      chk("R6", "rd_vld", {7'd0, rd_vld}, {7'd0, e.rv});
      if (e.rv) chk("R6", "rd_addr", rd_addr, e.ra);
      chk("R8", "err", {7'd0, err}, {7'd0, e.er});
      chk("R5", "full", {7'd0, full}, {7'd0, e.fu});
      chk("R7", "empty", {7'd0, empty}, {7'd0, e.em});
      chk("R9", "newest_addr", newest_addr, e.nw);
      if (wr_vld) begin
        obs_wr.push_back(wr_addr);
        chk("R10", "wr bit4", {7'd0, wr_addr[4]}, 8'd1);
      end
      if (rd_vld) chk("R10", "rd bit4", {7'd0, rd_addr[4]}, 8'd1);
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // Configuration A: ring ends mid-bank at 0x54
    do_reset(8'h1A, 8'h54, 8'd26);
    run(30, 1'b1, 1'b0);        // fill past full
    run(2, 1'b1, 1'b1);         // full: only pop taken
    run(30, 1'b0, 1'b1);        // drain past empty
    run(2, 1'b1, 1'b1);         // empty: only push taken
    run(10, 1'b1, 1'b0);
    run(60, 1'b1, 1'b1);        // dual traffic across several wraps
    run(20, 1'b0, 1'b1);
    run(2, 1'b0, 1'b0);
    chk("R1", "first push addr", obs_wr[0], 8'h1A);
    chk("R2", "bank hop 1F->30", obs_wr[6], 8'h30);
    chk("R2", "bank hop 3F->50", obs_wr[22], 8'h50);
    chk("R3", "wrap to base", obs_wr[26], 8'h1A);

    // Configuration B: ring crosses 0xFF into 0x10
    do_reset(8'hF8, 8'h38, 8'd20);
    run(24, 1'b1, 1'b0);
    run(40, 1'b1, 1'b1);
    run(24, 1'b0, 1'b1);
    run(36, 1'b1, 1'b1);
    run(2, 1'b0, 1'b0);
    chk("R2", "top wrap FF->10", obs_wr[8], 8'h10);
    chk("R3", "wrap at 0x38", obs_wr[32], 8'hF8);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule